// File: doc/BRIEF.md
# Modulo-5 Event Counter with Quotient

This block counts single-cycle strobes on an event input. It reports the running count in two parts: the remainder after division by five, and the number of completed groups of five, which is the quotient. Everything is synchronous to one clock. The event input must already be synchronized to that clock. A synchronous clear input returns both parts to zero.

Internally the remainder is a small state machine with two phases. Phase `PH_BELOW` covers remainders 0 to 3. Phase `PH_TOP` covers remainder 4, where the next event carries. The transitions are:

- `BELOW->BELOW` steps the remainder by one.
- `BELOW->TOP` happens when an event arrives at remainder 3.
- `TOP->BELOW` happens on the carry event.
- Clear forces `PH_BELOW` from either phase.

A separate quotient counter advances only on the carry strobe that the remainder stage emits.

Top module: `mod5_event_counter`

## Requirements
- R1: An event sampled on a rising edge while the remainder is 0 to 3 raises the remainder by one after that edge. The quotient is left unchanged.
- R2: An event sampled while the remainder equals 4 sets the remainder to 0 and raises the quotient by one, both on the same edge.
- R3: The 4-bit quotient wraps from 15 to 0 on the next carry. After 80 events from clear, both outputs read 0.
- R4: A high clear input at a rising edge sets the remainder and the quotient to 0 after that edge.
- R5: When clear and event are both high in the same cycle, the clear wins and the event is not counted.
- R6: A cycle with event low and clear low leaves both outputs unchanged.
- R7: An event input held high for N consecutive cycles counts as N events.
- R8: The 3-bit remainder output always lies in the range 0 to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| init | input | 1 | Synchronous clear of both counts, active high |
| evt | input | 1 | Event strobe; one count per cycle that it is high |
| rem_o | output | 3 | Count modulo 5 (registered) |
| quo_o | output | 4 | Count divided by 5, modulo 16 (registered) |

## Verification
Every result is due one edge after the stimulus. An event, or a clear, sampled at a rising edge appears on both outputs just after that same edge, because each output comes straight from a single register stage. The carry into the quotient is combinational from the remainder phase, so it adds no cycle of delay.

The bench therefore drives inputs on the falling edge. It samples the outputs a short time after the following rising edge and compares them with a count it keeps itself.

// File: rtl/mod5_cnt_pkg.sv
package mod5_cnt_pkg;
    typedef enum logic {
        PH_BELOW = 1'b0,
        PH_TOP   = 1'b1
    } rem_phase_t;
endpackage

// File: rtl/mod5_rem_fsm.sv
module mod5_rem_fsm
    import mod5_cnt_pkg::*;
#(
    parameter int MODULUS = 5,
    parameter int REM_W   = $clog2(MODULUS)
) (
    input  logic             clk,
    input  logic             init,
    input  logic             evt,
    output logic [REM_W-1:0] rem,
    output logic             carry
);
    localparam logic [REM_W-1:0] LAST_V = REM_W'(MODULUS - 1);
    localparam logic [REM_W-1:0] PRE_V  = REM_W'(MODULUS - 2);

    rem_phase_t       phase, phase_nx;
    logic [REM_W-1:0] rem_nx;

    // next-state and output process
    always_comb begin
        phase_nx = phase;
        rem_nx   = rem;
        carry    = 1'b0;
        unique case (phase)
            PH_BELOW: begin
                if (evt) begin
                    rem_nx   = rem + 1'b1;
                    phase_nx = (rem == PRE_V) ? PH_TOP : PH_BELOW;
                end
            end
            PH_TOP: begin
                if (evt) begin
                    rem_nx   = '0;
                    phase_nx = PH_BELOW;
                    carry    = 1'b1;
                end
            end
            default: phase_nx = PH_BELOW;
        endcase
        if (init) begin
            rem_nx   = '0;
            phase_nx = PH_BELOW;
            carry    = 1'b0;
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        phase <= phase_nx;
        rem   <= rem_nx;
    end

    AST_PHASE_TOP: assert property (@(posedge clk) disable iff (init)
        (phase == PH_TOP) |-> (rem == LAST_V)); // R2
    AST_REM_RANGE: assert property (@(posedge clk) disable iff (init)
        (rem <= LAST_V)); // R8
endmodule

// File: rtl/mod5_quo_cnt.sv
module mod5_quo_cnt #(
    parameter int QUO_W = 4
) (
    input  logic             clk,
    input  logic             init,
    input  logic             carry,
    output logic [QUO_W-1:0] quo
);
    // natural binary wrap gives modulo 2**QUO_W
    always_ff @(posedge clk) begin
        if (init)       quo <= '0;
        else if (carry) quo <= quo + 1'b1;
    end

    AST_QUO_HOLD: assert property (@(posedge clk) disable iff (init)
        !carry |=> $stable(quo)); // R6
endmodule

// File: rtl/mod5_event_counter.sv
module mod5_event_counter #(
    parameter int MODULUS = 5,
    parameter int QUO_W   = 4,
    parameter int REM_W   = $clog2(MODULUS)
) (
    input  logic             clk,
    input  logic             init,
    input  logic             evt,
    output logic [REM_W-1:0] rem_o,
    output logic [QUO_W-1:0] quo_o
);
    localparam logic [REM_W-1:0] LAST_V = REM_W'(MODULUS - 1);

    logic carry;

    mod5_rem_fsm #(.MODULUS(MODULUS), .REM_W(REM_W)) u_rem (
        .clk(clk), .init(init), .evt(evt), .rem(rem_o), .carry(carry)
    );

    mod5_quo_cnt #(.QUO_W(QUO_W)) u_quo (
        .clk(clk), .init(init), .carry(carry), .quo(quo_o)
    );

    AST_CLEAR: assert property (@(posedge clk) disable iff (init)
        $past(init) |-> (rem_o == '0 && quo_o == '0)); // R4
    AST_STEP: assert property (@(posedge clk) disable iff (init)
        (evt && rem_o != LAST_V) |=>
            (rem_o == REM_W'($past(rem_o) + 1'b1) && $stable(quo_o))); // R1
    AST_CARRY: assert property (@(posedge clk) disable iff (init)
        (evt && rem_o == LAST_V) |=>
            (rem_o == '0 && quo_o == QUO_W'($past(quo_o) + 1'b1))); // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (init)
        !evt |=> ($stable(rem_o) && $stable(quo_o))); // R6
endmodule

// File: tb/mod5_event_counter_tb.sv
module mod5_event_counter_tb;
    logic       clk = 1'b0;
    logic       init = 1'b1;
    logic       evt = 1'b0;
    logic [2:0] rem_o;
    logic [3:0] quo_o;
    int         n_run = 0;
    int         n_fail = 0;
    int         count = 0;

    always #2.5 clk = ~clk; // 200 MHz

    mod5_event_counter u_dut (
        .clk(clk), .init(init), .evt(evt), .rem_o(rem_o), .quo_o(quo_o)
    );

    // {init, evt, expected rem, expected quo}
    localparam int NV = 17;
    localparam logic [8:0] VEC [NV] = '{
        {1'b1, 1'b0, 3'd0, 4'd0},  // R4 clear
        {1'b1, 1'b1, 3'd0, 4'd0},  // R5 clear beats event
        {1'b0, 1'b1, 3'd1, 4'd0},  // R1
        {1'b0, 1'b0, 3'd1, 4'd0},  // R6 hold
        {1'b0, 1'b1, 3'd2, 4'd0},
        {1'b0, 1'b1, 3'd3, 4'd0},
        {1'b0, 1'b1, 3'd4, 4'd0},
        {1'b0, 1'b0, 3'd4, 4'd0},  // R6 hold at top
        {1'b0, 1'b1, 3'd0, 4'd1},  // R2 carry
        {1'b0, 1'b1, 3'd1, 4'd1},
        {1'b0, 1'b1, 3'd2, 4'd1},
        {1'b1, 1'b1, 3'd0, 4'd0},  // R5 clear mid-count
        {1'b0, 1'b1, 3'd1, 4'd0},
        {1'b0, 1'b1, 3'd2, 4'd0},
        {1'b0, 1'b1, 3'd3, 4'd0},
        {1'b0, 1'b1, 3'd4, 4'd0},
        {1'b0, 1'b1, 3'd0, 4'd1}   // R7 held strobe, R2
    };

    task automatic check(input string req, input logic [2:0] er, input logic [3:0] eq);
        n_run++;
        if (rem_o !== er || quo_o !== eq) begin
            n_fail++;
            $display("FAIL %s: rem=%0d quo=%0d expected rem=%0d quo=%0d",
                     req, rem_o, quo_o, er, eq);
        end
    endtask

    task automatic step(input logic i, input logic e);
        @(negedge clk);
        init = i;
        evt  = e;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog: rem=%0d quo=%0d expected run to end", rem_o, quo_o);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int v = 0; v < NV; v++) begin
            step(VEC[v][8], VEC[v][7]);
            check("R1/R2/R4/R5/R6 table", VEC[v][6:4], VEC[v][3:0]);
        end

        // R3 and R7: strobe held high for 80 cycles from clear
        step(1'b1, 1'b0);
        check("R4", 3'd0, 4'd0);
        count = 0;
        for (int k = 0; k < 80; k++) begin
            step(1'b0, 1'b1);
            count++;
            check("R7", 3'(count % 5), 4'((count / 5) % 16));
            n_run++;
            if (rem_o > 3'd4) begin
                n_fail++;
                $display("FAIL R8: rem=%0d expected <=4", rem_o);
            end
        end
        check("R3 wrap", 3'd0, 4'd0);

        // R6: idle cycles hold a nonzero state
        for (int k = 0; k < 7; k++) step(1'b0, 1'b1);
        check("R2", 3'd2, 4'd1);
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b0);
            check("R6", 3'd2, 4'd1);
        end

        // R5: clear with event while at remainder 4
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        check("R1", 3'd4, 4'd1);
        step(1'b1, 1'b1);
        check("R5", 3'd0, 4'd0);
        step(1'b0, 1'b0);
        check("R4", 3'd0, 4'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule